// File: doc/BRIEF.md
# Programmable-Priority Memory Bus Arbiter

This block lets three bus masters share one data memory port: a CPU, a DMA controller and a debug port. Each master presents a request together with an address, write data and a write enable. In every cycle the arbiter grants exactly one of the requesting masters and drives that master's access onto the shared memory port. Every other requester sees a stall and must keep its access steady until it is granted. Read data comes back from the single-cycle memory one cycle after the grant, and only the master that issued the read receives it.

A 16-bit control word, written through a simple register-write port, selects one of two priority orders. In the default order the CPU wins over the DMA, and the DMA wins over the debug port. Setting bit 5 (the value 0x0020) moves the DMA above the CPU. The debug port stays lowest in both orders. Software may set the order once at start-up or change it while traffic is running. A new setting applies from the next arbitration decision onward. It never affects a decision that has already been made.

Top module: `mba_arbiter`

## Requirements
- R1: After reset, the control word reads 0x0000, and no grant and no stall is asserted while no master requests.
- R2: With the control word at 0x0000, the CPU wins over the DMA, and the DMA wins over the debug port.
- R3: Writing 0x0020 (bit 5 set) makes the DMA win over the CPU, and the control word then reads 0x0020. Writing 0x0000 restores the order of R2.
- R4: A write of any value other than 0x0000 or 0x0020 leaves the active order and the read-back value unchanged.
- R5: Grants are one-hot or zero. A grant goes only to a requesting master, and some master is granted whenever at least one requests.
- R6: A master's stall is high exactly when it requests and is not granted.
- R7: In a grant cycle, the memory port carries the winner's address, write data and write enable, with the memory enable high. With no grant, the enable is low.
- R8: For a granted read, the memory data appears on that master's read-data output in the next cycle. The other masters' read-data outputs are zero.
- R9: The debug port is granted only in cycles where neither the CPU nor the DMA requests, under either order.
- R10: A control write governs decisions from the cycle after the write. The decision in the write cycle itself uses the old order.
- R11: Suspended masters are served in priority order as the higher-priority requesters drop away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Active control word (0x0000 or 0x0020) |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | 12 | CPU address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_gnt | output | 1 | CPU granted this cycle |
| cpu_stall | output | 1 | CPU held off |
| cpu_rdata | output | 16 | CPU read data, one cycle after a read grant |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write enable |
| dma_addr | input | 12 | DMA address |
| dma_wdata | input | 16 | DMA write data |
| dma_gnt | output | 1 | DMA granted this cycle |
| dma_stall | output | 1 | DMA held off |
| dma_rdata | output | 16 | DMA read data, one cycle after a read grant |
| dbg_req | input | 1 | Debug port access request |
| dbg_we | input | 1 | Debug port write enable |
| dbg_addr | input | 12 | Debug port address |
| dbg_wdata | input | 16 | Debug port write data |
| dbg_gnt | output | 1 | Debug port granted this cycle |
| dbg_stall | output | 1 | Debug port held off |
| dbg_rdata | output | 16 | Debug port read data, one cycle after a read grant |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, registered inside the memory |

## Verification
The only internal state is the one-bit order selector and the registered grant used to return read data. A corrupted order bit shows up in the first cycle in which the CPU and the DMA request together, as the wrong grant. It also shows up at once on the control read-back. A corrupted returned-grant register shows up one cycle after a read, as data on the wrong master's read port or zero on the right one. Each fault is therefore visible within one or two cycles of the stimulus that exposes it.

// File: rtl/mba_pkg.sv
package mba_pkg;

    localparam int unsigned NUM_MST = 3;

    typedef enum logic [1:0] {
        MST_CPU = 2'd0,
        MST_DMA = 2'd1,
        MST_DBG = 2'd2
    } mst_e;

    typedef enum logic {
        ORD_CPU_FIRST = 1'b0,
        ORD_DMA_FIRST = 1'b1
    } order_e;

    // Rank of a master under an order: 0 is the strongest.
    function automatic logic [1:0] rank_of(input mst_e m, input order_e ord);
        logic [1:0] r;
        case (m)
            MST_CPU: r = (ord == ORD_DMA_FIRST) ? 2'd1 : 2'd0;
            MST_DMA: r = (ord == ORD_DMA_FIRST) ? 2'd0 : 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mba_prio_reg.sv
module mba_prio_reg
    import mba_pkg::*;
#(
    parameter int unsigned CFG_W      = 16,
    parameter int unsigned DMA_UP_BIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output order_e           ord,
    output logic [CFG_W-1:0] cfg_rdata
);

    localparam logic [CFG_W-1:0] VAL_DEF = '0;
    localparam logic [CFG_W-1:0] VAL_DMA = CFG_W'(1) << DMA_UP_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            ord <= ORD_CPU_FIRST;
        end else if (cfg_we) begin
            if (cfg_wdata == VAL_DEF) begin
                ord <= ORD_CPU_FIRST;
            end else if (cfg_wdata == VAL_DMA) begin
                ord <= ORD_DMA_FIRST;
            end
        end
    end

    assign cfg_rdata = (ord == ORD_DMA_FIRST) ? VAL_DMA : VAL_DEF;

endmodule

// File: rtl/mba_grant.sv
module mba_grant
    import mba_pkg::*;
(
    input  logic [NUM_MST-1:0] req,
    input  order_e             ord,
    output logic [NUM_MST-1:0] gnt
);

    logic [1:0] best_rank;
    logic [1:0] win;
    logic       found;

    always_comb begin
        best_rank = 2'd3;
        win       = 2'd0;
        found     = 1'b0;
        for (int m = 0; m < NUM_MST; m++) begin
            if (req[m] && (rank_of(mst_e'(m), ord) < best_rank)) begin
                best_rank = rank_of(mst_e'(m), ord);
                win       = 2'(m);
                found     = 1'b1;
            end
        end
        gnt = '0;
        if (found) begin
            gnt[win] = 1'b1;
        end
    end

endmodule

// File: rtl/mba_datapath.sv
module mba_datapath
    import mba_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_MST-1:0]             gnt,
    input  logic [NUM_MST-1:0]             we,
    input  logic [NUM_MST-1:0][ADDR_W-1:0] addr,
    input  logic [NUM_MST-1:0][DATA_W-1:0] wdata,
    output logic                           mem_en,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]              mem_wdata,
    input  logic [DATA_W-1:0]              mem_rdata,
    output logic [NUM_MST-1:0][DATA_W-1:0] rdata
);

    logic [NUM_MST-1:0] rd_q;

    always_comb begin
        mem_en    = |gnt;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int m = 0; m < NUM_MST; m++) begin
            if (gnt[m]) begin
                mem_we    = we[m];
                mem_addr  = addr[m];
                mem_wdata = wdata[m];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= gnt & ~we;
        end
    end

    for (genvar g = 0; g < NUM_MST; g++) begin : g_ret
        assign rdata[g] = rd_q[g] ? mem_rdata : '0;
    end

endmodule

// File: rtl/mba_arbiter.sv
module mba_arbiter
    import mba_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CFG_W      = 16,
    parameter int unsigned DMA_UP_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_gnt,
    output logic              cpu_stall,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              dma_gnt,
    output logic              dma_stall,
    output logic [DATA_W-1:0] dma_rdata,
    input  logic              dbg_req,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic              dbg_gnt,
    output logic              dbg_stall,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    order_e                         ord;
    logic [NUM_MST-1:0]             req;
    logic [NUM_MST-1:0]             gnt;
    logic [NUM_MST-1:0]             we;
    logic [NUM_MST-1:0][ADDR_W-1:0] addr;
    logic [NUM_MST-1:0][DATA_W-1:0] wdata;
    logic [NUM_MST-1:0][DATA_W-1:0] rdata;
    logic [NUM_MST-1:0]             stall;

    assign req   = {dbg_req, dma_req, cpu_req};
    assign we    = {dbg_we, dma_we, cpu_we};
    assign addr  = {dbg_addr, dma_addr, cpu_addr};
    assign wdata = {dbg_wdata, dma_wdata, cpu_wdata};

    mba_prio_reg #(
        .CFG_W      (CFG_W),
        .DMA_UP_BIT (DMA_UP_BIT)
    ) u_prio (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ord       (ord),
        .cfg_rdata (cfg_rdata)
    );

    mba_grant u_grant (
        .req (req),
        .ord (ord),
        .gnt (gnt)
    );

    mba_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .gnt       (gnt),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .rdata     (rdata)
    );

    assign stall = req & ~gnt;

    assign cpu_gnt   = gnt[MST_CPU];
    assign dma_gnt   = gnt[MST_DMA];
    assign dbg_gnt   = gnt[MST_DBG];
    assign cpu_stall = stall[MST_CPU];
    assign dma_stall = stall[MST_DMA];
    assign dbg_stall = stall[MST_DBG];
    assign cpu_rdata = rdata[MST_CPU];
    assign dma_rdata = rdata[MST_DMA];
    assign dbg_rdata = rdata[MST_DBG];

endmodule

// File: rtl/mba_arbiter_chk.sv
module mba_arbiter_chk #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CFG_W      = 16,
    parameter int unsigned DMA_UP_BIT = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_gnt,
    input logic              cpu_stall,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              dma_req,
    input logic              dma_gnt,
    input logic              dma_stall,
    input logic              dbg_req,
    input logic              dbg_gnt,
    input logic              dbg_stall,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata
);

    localparam logic [CFG_W-1:0] CFG_DMA = CFG_W'(1) << DMA_UP_BIT;

    // R5
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dbg_gnt, dma_gnt, cpu_gnt}));

    // R5
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (({dbg_gnt, dma_gnt, cpu_gnt} & ~{dbg_req, dma_req, cpu_req}) == 3'b000));

    // R5
    req_served_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req || dma_req || dbg_req) |-> (cpu_gnt || dma_gnt || dbg_gnt));

    // R6
    stall_no_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall || dma_stall || dbg_stall) |-> mem_en);

    // R2
    cpu_first_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == '0 && cpu_req) |-> cpu_gnt);

    // R3
    dma_first_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == CFG_DMA && dma_req) |-> dma_gnt);

    // R4
    cfg_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == '0) || (cfg_rdata == CFG_DMA));

    // R9
    dbg_last_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_gnt |-> (!cpu_req && !dma_req));

    // R7
    mem_addr_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_gnt |-> (mem_addr == cpu_addr));

    // R8
    rd_return_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt && !cpu_we) |=> (cpu_rdata == mem_rdata));

endmodule

bind mba_arbiter mba_arbiter_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CFG_W      (CFG_W),
    .DMA_UP_BIT (DMA_UP_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_gnt   (cpu_gnt),
    .cpu_stall (cpu_stall),
    .cpu_rdata (cpu_rdata),
    .dma_req   (dma_req),
    .dma_gnt   (dma_gnt),
    .dma_stall (dma_stall),
    .dbg_req   (dbg_req),
    .dbg_gnt   (dbg_gnt),
    .dbg_stall (dbg_stall),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
);

// File: tb/mba_arbiter_bench.sv
module mba_arbiter_bench;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned CFG_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [CFG_W-1:0]  cfg_rdata;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_gnt, cpu_stall;
    logic [DATA_W-1:0] cpu_rdata;
    logic              dma_req = 1'b0, dma_we = 1'b0;
    logic [ADDR_W-1:0] dma_addr = '0;
    logic [DATA_W-1:0] dma_wdata = '0;
    logic              dma_gnt, dma_stall;
    logic [DATA_W-1:0] dma_rdata;
    logic              dbg_req = 1'b0, dbg_we = 1'b0;
    logic [ADDR_W-1:0] dbg_addr = '0;
    logic [DATA_W-1:0] dbg_wdata = '0;
    logic              dbg_gnt, dbg_stall;
    logic [DATA_W-1:0] dbg_rdata;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    mba_arbiter u_mba_arbiter (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_gnt(dma_gnt), .dma_stall(dma_stall), .dma_rdata(dma_rdata),
        .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_gnt(dbg_gnt), .dbg_stall(dbg_stall), .dbg_rdata(dbg_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Single-cycle SRAM model
    logic [DATA_W-1:0] sram [256];
    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) sram[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= sram[mem_addr[7:0]];
        end
    end

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // {order bit, req {dbg,dma,cpu}, expected gnt {dbg,dma,cpu}}
    localparam logic [6:0] VEC [14] = '{
        7'b0_000_000, 7'b0_001_001, 7'b0_010_010, 7'b0_011_001,
        7'b0_100_100, 7'b0_101_001, 7'b0_110_010, 7'b0_111_001,
        7'b1_011_010, 7'b1_111_010, 7'b1_101_001, 7'b1_110_010,
        7'b1_100_100, 7'b1_001_001
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 cfg_rdata", 32'(cfg_rdata), 32'h0);
        chk("R1 grants", {29'd0, dbg_gnt, dma_gnt, cpu_gnt}, 32'h0);
        chk("R1 stalls", {29'd0, dbg_stall, dma_stall, cpu_stall}, 32'h0);

        // Table walk: R2 / R3 orders, R9 debug lowest, R5 grant, R6 stall
        for (int i = 0; i < 14; i++) begin
            logic [2:0] rq;
            logic [2:0] eg;
            rq = VEC[i][5:3];
            eg = VEC[i][2:0];
            if (VEC[i][6] != (cfg_rdata == 16'h0020)) begin
                write_cfg(VEC[i][6] ? 16'h0020 : 16'h0000);
                chk("R3 readback", 32'(cfg_rdata), VEC[i][6] ? 32'h20 : 32'h0);
            end
            @(negedge clk);
            {dbg_req, dma_req, cpu_req} = rq;
            #1;
            chk(VEC[i][6] ? "R3 R9 R5 gnt" : "R2 R9 R5 gnt",
                {29'd0, dbg_gnt, dma_gnt, cpu_gnt}, {29'd0, eg});
            chk("R6 stall", {29'd0, dbg_stall, dma_stall, cpu_stall}, {29'd0, rq & ~eg});
        end
        @(negedge clk);
        {dbg_req, dma_req, cpu_req} = 3'b000;

        // R4 reserved writes ignored (currently DMA-first)
        write_cfg(16'h0021);
        chk("R4 readback", 32'(cfg_rdata), 32'h20);
        @(negedge clk);
        cpu_req = 1'b1; dma_req = 1'b1;
        #1;
        chk("R4 order kept", {30'd0, dma_gnt, cpu_gnt}, 32'b10);
        @(negedge clk);
        cpu_req = 1'b0; dma_req = 1'b0;
        write_cfg(16'h0000);
        chk("R3 restore", 32'(cfg_rdata), 32'h0);
        write_cfg(16'h0010);
        chk("R4 readback default", 32'(cfg_rdata), 32'h0);

        // R10 change applies from the next decision
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'h0020;
        cpu_req = 1'b1; dma_req = 1'b1;
        #1;
        chk("R10 same cycle old order", {30'd0, dma_gnt, cpu_gnt}, 32'b01);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R10 next cycle new order", {30'd0, dma_gnt, cpu_gnt}, 32'b10);
        chk("R10 cpu stalled", 32'(cpu_stall), 32'h1);
        @(negedge clk);
        cpu_req = 1'b0; dma_req = 1'b0;
        write_cfg(16'h0000);

        // R11 suspended masters served in priority order
        @(negedge clk);
        {dbg_req, dma_req, cpu_req} = 3'b111;
        #1;
        chk("R11 step cpu", {29'd0, dbg_gnt, dma_gnt, cpu_gnt}, 32'b001);
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        chk("R11 step dma", {29'd0, dbg_gnt, dma_gnt, cpu_gnt}, 32'b010);
        chk("R11 dbg still stalled", 32'(dbg_stall), 32'h1);
        @(negedge clk);
        dma_req = 1'b0;
        #1;
        chk("R11 step dbg", {29'd0, dbg_gnt, dma_gnt, cpu_gnt}, 32'b100);
        @(negedge clk);
        dbg_req = 1'b0;

        // R7 write path and R8 read return
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 12'h005; cpu_wdata = 16'hBEEF;
        #1;
        chk("R7 mem_en", 32'(mem_en), 32'h1);
        chk("R7 mem_we", 32'(mem_we), 32'h1);
        chk("R7 mem_addr", 32'(mem_addr), 32'h005);
        chk("R7 mem_wdata", 32'(mem_wdata), 32'hBEEF);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        dma_req = 1'b1; dma_addr = 12'h005;
        #1;
        chk("R7 dma read addr", 32'(mem_addr), 32'h005);
        chk("R7 mem_we low", 32'(mem_we), 32'h0);
        @(negedge clk);
        dma_req = 1'b0;
        #1;
        chk("R8 dma rdata", 32'(dma_rdata), 32'hBEEF);
        chk("R8 cpu rdata zero", 32'(cpu_rdata), 32'h0);
        chk("R8 dbg rdata zero", 32'(dbg_rdata), 32'h0);
        chk("R7 idle mem_en", 32'(mem_en), 32'h0);
        @(negedge clk);
        #1;
        chk("R8 rdata cleared", 32'(dma_rdata), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule